// File: doc/BRIEF.md
# Attached Target Characteristics Table

This block keeps a small associative table describing the targets that currently sit on a two-wire serial bus: whether each one is attached, whether it is a legacy I2C device or an I3C device, and the two capability bits that govern in-band interrupts. Entries are found by matching the 7-bit bus address, not by an index. Software sees the whole table through one 16-bit register.

A register write with the write-enable bit clear only selects an address. The read data then shows that address with its stored flags. A write with write-enable set creates the entry for that address, or updates it if it already exists. Clearing the attached flag removes the entry and frees its storage. A separate combinational lookup port serves the bus engine. When an interrupt request arrives from an address, the port reports whether to acknowledge it and whether a data byte follows.

Register fields: bit 0 is the I2C flag, bit 1 is the attached flag, bits 3:2 carry capability bits 2:1 of the target, bits 7:4 are reserved, bit 8 is write-enable, and bits 15:9 are the address.

Top module: `dev_char_table`

## Requirements
- R1: After reset the table is empty, `reg_rdata` is all zero, `ibi_ack` and `ibi_has_data` are low, and `tbl_full_err` is low.
- R2: A write with bit 8 clear selects the address in bits 15:9. From the next cycle, `reg_rdata[15:9]` shows that address, and bits 8:4 read as zero. Bits 7:4 are always written as zero.
- R3: A write with bit 8 set and bit 1 set, to an address not yet stored, allocates a free entry. A later selection of that address reads back bit 0, bit 1 = 1 and bits 3:2 exactly as written.
- R4: A write with bit 8 set to an address already stored replaces its flags in place and takes no further storage.
- R5: A write with bit 8 set and bit 1 clear to a stored address removes it. Its read-back flags become zero, and its storage can be allocated again.
- R6: When all ENTRIES slots are in use, an attaching write to a new address is ignored and `tbl_full_err` rises. The flag stays high until reset.
- R7: Selecting an address that is not stored reads back zero in bits 3:0.
- R8: `ibi_ack` is high only when `ibi_addr` matches a stored entry that is not I2C (bit 0 = 0) and has its request-capable bit set (register bit 2).
- R9: `ibi_has_data` is high when `ibi_ack` is high and the entry's data-byte bit (register bit 3) is set.
- R10: A write with bit 8 set and bit 1 clear to an address that is not stored changes nothing and does not raise `tbl_full_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Selected address and its flags |
| tbl_full_err | output | 1 | Sticky: an attach was dropped because the table was full |
| ibi_addr | input | 7 | Address requesting an interrupt |
| ibi_ack | output | 1 | Acknowledge the request |
| ibi_has_data | output | 1 | Request carries one data byte |

## Verification
A register write takes effect at the first rising edge that sees `reg_wr`. Read data, both lookup outputs and the error flag all depend on the registered table through combinational paths only. Every result is therefore due one cycle after its write. The bench drives each vector on a falling edge and checks it on the next falling edge, after exactly one capturing edge. Lookup-only vectors hold `reg_wr` low, so the values checked there come from the state left by earlier writes.

// File: rtl/dev_char_table.sv
`timescale 1ns/1ps
module dev_char_table #(
  parameter int ENTRIES = 16,
  parameter int AW      = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        tbl_full_err,
  input  logic [6:0]  ibi_addr,
  output logic        ibi_ack,
  output logic        ibi_has_data
);
  localparam int B_I2C = 0;
  localparam int B_ATT = 1;
  localparam int B_WEN = 8;
  localparam int A_LO  = 9;

  logic [ENTRIES-1:0] used;
  logic [AW-1:0]      tag  [ENTRIES];
  logic               is_i2c [ENTRIES];
  logic [1:0]         caps [ENTRIES];
  logic [AW-1:0]      sel_addr;

  wire [AW-1:0] w_addr = reg_wdata[A_LO +: AW];
  wire          w_en   = reg_wdata[B_WEN];
  wire          w_att  = reg_wdata[B_ATT];
  wire [1:0]    w_caps = reg_wdata[3:2];

  logic [ENTRIES-1:0] wr_hit, rd_hit, ibi_hit;
  for (genvar i = 0; i < ENTRIES; i++) begin : g_match
    assign wr_hit[i]  = used[i] && (tag[i] == w_addr);
    assign rd_hit[i]  = used[i] && (tag[i] == sel_addr);
    assign ibi_hit[i] = used[i] && (tag[i] == ibi_addr[AW-1:0]);
  end

  wire [ENTRIES-1:0] free_oh = ~used & (used + 1'b1);
  wire               any_wr_hit = |wr_hit;
  wire               is_full = &used;

  logic [3:0] rd_flags;
  logic       ibi_i2c;
  logic [1:0] ibi_caps;
  always_comb begin
    rd_flags = '0;
    ibi_i2c  = 1'b0;
    ibi_caps = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rd_hit[i])  rd_flags = rd_flags | {caps[i], 1'b1, is_i2c[i]};
      if (ibi_hit[i]) begin
        ibi_i2c  = ibi_i2c | is_i2c[i];
        ibi_caps = ibi_caps | caps[i];
      end
    end
  end

  assign reg_rdata    = {sel_addr, 5'b0, rd_flags};
  assign ibi_ack      = (|ibi_hit) && !ibi_i2c && ibi_caps[0];
  assign ibi_has_data = ibi_ack && ibi_caps[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used         <= '0;
      sel_addr     <= '0;
      tbl_full_err <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag[i]    <= '0;
        is_i2c[i] <= 1'b0;
        caps[i]   <= '0;
      end
    end else if (reg_wr) begin
      if (!w_en) begin
        sel_addr <= w_addr;
      end else if (any_wr_hit) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (wr_hit[i]) begin
            used[i]   <= w_att;
            is_i2c[i] <= reg_wdata[B_I2C];
            caps[i]   <= w_caps;
          end
        end
      end else if (w_att) begin
        if (is_full) tbl_full_err <= 1'b1;
        for (int i = 0; i < ENTRIES; i++) begin
          if (free_oh[i]) begin
            used[i]   <= 1'b1;
            tag[i]    <= w_addr;
            is_i2c[i] <= reg_wdata[B_I2C];
            caps[i]   <= w_caps;
          end
        end
      end
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> reg_wdata[7:4] == 4'b0); // R2
  AST_SEL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !w_en) |=> reg_rdata[15:9] == $past(w_addr)); // R2
  AST_NO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ibi_hit)); // R4
  AST_DETACH: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && w_en && !w_att && w_addr == reg_rdata[15:9]) |=> !reg_rdata[1]); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_full_err |=> tbl_full_err); // R6
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tbl_full_err) |-> $past(reg_wr && w_en && w_att && is_full)); // R6
  AST_DATA_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ibi_has_data |-> ibi_ack); // R9
endmodule

// File: tb/test_dev_char_table.sv
`timescale 1ns/1ps
module test_dev_char_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        tbl_full_err;
  logic [6:0]  ibi_addr = '0;
  logic        ibi_ack, ibi_has_data;
  int          n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  dev_char_table i_dev_char_table (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tbl_full_err(tbl_full_err), .ibi_addr(ibi_addr),
    .ibi_ack(ibi_ack), .ibi_has_data(ibi_has_data));

  function automatic logic [15:0] enc(input logic [6:0] a, input logic we,
                                      input logic [1:0] cp, input logic att, input logic i2c);
    return {a, we, 3'b0, 1'b0, cp, att, i2c};
  endfunction

  function automatic logic [42:0] vec(input logic wr, input logic [15:0] wd, input logic [6:0] ia,
                                      input logic [15:0] rd, input logic ack, input logic dat,
                                      input logic err);
    return {wr, wd, ia, rd, ack, dat, err};
  endfunction

  localparam int NV = 13;
  localparam logic [42:0] VT [NV] = '{
    vec(1, enc(7'h10,0,0,0,0), 7'h10, enc(7'h10,0,0,0,0), 0,0,0), // R2 R7
    vec(1, enc(7'h10,1,3,1,0), 7'h10, enc(7'h10,0,3,1,0), 1,1,0), // R3 R8 R9
    vec(1, enc(7'h22,1,1,1,1), 7'h22, enc(7'h10,0,3,1,0), 0,0,0), // R8 i2c never acked
    vec(1, enc(7'h22,0,0,0,0), 7'h22, enc(7'h22,0,1,1,1), 0,0,0), // R3
    vec(1, enc(7'h31,1,1,1,0), 7'h31, enc(7'h22,0,1,1,1), 1,0,0), // R8 R9
    vec(1, enc(7'h31,1,0,1,0), 7'h31, enc(7'h22,0,1,1,1), 0,0,0), // R4
    vec(1, enc(7'h31,0,0,0,0), 7'h31, enc(7'h31,0,0,1,0), 0,0,0), // R4
    vec(1, enc(7'h10,1,2,1,0), 7'h10, enc(7'h31,0,0,1,0), 0,0,0), // R9 data bit without capable bit
    vec(1, enc(7'h22,1,0,0,1), 7'h22, enc(7'h31,0,0,1,0), 0,0,0), // R5
    vec(1, enc(7'h22,0,0,0,0), 7'h22, enc(7'h22,0,0,0,0), 0,0,0), // R5
    vec(0, 16'h0,              7'h55, enc(7'h22,0,0,0,0), 0,0,0), // R7 lookup miss
    vec(1, enc(7'h55,1,3,0,0), 7'h55, enc(7'h22,0,0,0,0), 0,0,0), // R10
    vec(1, enc(7'h55,0,0,0,0), 7'h55, enc(7'h55,0,0,0,0), 0,0,0)  // R10 R7
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [15:0] wd, input logic [6:0] ia);
    @(negedge clk);
    reg_wr = wr; reg_wdata = wd; ibi_addr = ia;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata", reg_rdata, 16'h0);
    check("R1 ack/data/err", {13'b0, ibi_ack, ibi_has_data, tbl_full_err}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      step(VT[i][42], VT[i][41:26], VT[i][25:19]);
      check($sformatf("R2/R3/R4/R5/R7/R10 rdata v%0d", i), reg_rdata, VT[i][18:3]);
      check($sformatf("R8 ack v%0d", i), {15'b0, ibi_ack}, {15'b0, VT[i][2]});
      check($sformatf("R9 data v%0d", i), {15'b0, ibi_has_data}, {15'b0, VT[i][1]});
      check($sformatf("R6 err v%0d", i), {15'b0, tbl_full_err}, {15'b0, VT[i][0]});
    end

    // 0x10 and 0x31 hold two entries; 14 more fill all 16 (R4: updates took none)
    for (int k = 0; k < 14; k++) step(1, enc(7'h40 + 7'(k), 1, 1, 1, 0), 7'h40 + 7'(k));
    check("R4 no error at exactly full", {15'b0, tbl_full_err}, 16'h0);
    check("R3 last fill acked", {15'b0, ibi_ack}, 16'h1);

    step(1, enc(7'h60, 1, 3, 1, 0), 7'h60);
    check("R6 err on overflow", {15'b0, tbl_full_err}, 16'h1);
    check("R6 dropped entry not acked", {15'b0, ibi_ack}, 16'h0);
    step(1, enc(7'h60, 0, 0, 0, 0), 7'h60);
    check("R6 dropped entry reads zero", reg_rdata, enc(7'h60, 0, 0, 0, 0));

    step(1, enc(7'h40, 1, 0, 0, 0), 7'h40);
    check("R5 detached not acked", {15'b0, ibi_ack}, 16'h0);
    check("R6 err sticky", {15'b0, tbl_full_err}, 16'h1);
    step(1, enc(7'h60, 1, 3, 1, 0), 7'h60);
    check("R5 freed slot reused", reg_rdata, enc(7'h60, 0, 3, 1, 0));
    check("R5 R8 reused entry acked", {14'b0, ibi_ack, ibi_has_data}, 16'h3);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    ibi_addr = 7'h60;
    @(negedge clk);
    check("R1 reset clears table", {13'b0, ibi_ack, ibi_has_data, tbl_full_err}, 16'h0);
    check("R1 reset rdata", reg_rdata, 16'h0);
    finish_run();
  end
endmodule